// File: doc/BRIEF.md
# Dual Down-Counter System Timer

This block contains two identical programmable down-counters, each `CNT_W` bits wide (32 by default). A counter is armed by software, decrements once for every cycle in which the shared `tick_i` strobe is high, and raises its status flag when it expires. Each counter runs in one of two modes. In periodic mode it reloads itself from its load register and keeps running. In one-shot mode it stops at zero and clears its own run bit.

A chaining switch joins the two counters into one down-counter of twice the width. Counter 0 holds the low word and counter 1 holds the high word. The high word moves only when the low word borrows. Counter 0's control and status bits govern the joined counter. Software reaches the load, current-value, control, status and mode registers through a single-cycle write port and a combinational read port.

Top module: `dual_systimer`

## Requirements
- R1: A synchronous active-high `rst` clears all load values, counts, control bits, status flags and the chaining bit, so every register reads 0 and `irq_o` is 0.
- R2: A counter whose run bit is set decrements by one on each clock edge at which `tick_i` is 1. It holds its value when `tick_i` is 0 or when its run bit is clear.
- R3: Expiry occurs on the tick that moves a count from 1 to 0. On that edge the counter's status flag is set. `irq_o[i]` equals status flag i AND the irq-enable bit of counter i.
- R4: In periodic mode, a tick that finds the count at 0 reloads the count from the load register. A load value L therefore gives an expiry every L+1 ticks.
- R5: In one-shot mode, the expiring tick also clears the run bit (control bit 0), so the count then stays at 0.
- R6: A load-register write copies the value into the count when the counter is stopped. While the counter is running, the write leaves the count alone, and the new value is used at the next reload.
- R7: In the status register, bit i is the flag of counter i. Writing 1 to bit i clears it, and writing 0 to it has no effect. If a hardware set and a clearing write fall on the same edge, the set wins.
- R8: A load value of 0 in periodic mode sets the flag on every tick.
- R9: When the chaining bit is 1, counter 0 is the low word and counter 1 is the high word of one double-width down-counter. The high word decrements only on ticks where the low word wraps from 0 to all-ones. Counter 0's run, one-shot and irq-enable bits govern the joined counter, including whether load writes reach the counts.
- R10: In chained mode, only status flag 0 is set, on the tick that takes the joined value from 1 to 0. `irq_o[1]` is held at 0.
- R11: When the two counters are not chained, activity on one counter changes neither the count, nor the flag, nor the interrupt of the other.
- R12: The registers are at these addresses: 0 load 0, 1 count 0 (read-only), 2 control 0, 3 load 1, 4 count 1 (read-only), 5 control 1, 6 status, 7 mode (bit 0 = chaining). In a control register, bit 0 is run, bit 1 is one-shot and bit 2 is irq enable. Unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count strobe; one decrement step per cycle when high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for `addr_i`, combinational |
| irq_o | output | 2 | Per-counter interrupt outputs |

## Verification
Every register write and every tick takes effect on the next clock edge. Counts, flags, control bits and `irq_o` are therefore due one cycle after the stimulus, and `rdata_o` reflects the new state in the same cycle without an extra register. The bench drives its inputs shortly after the falling edge and compares `irq_o` and `rdata_o` with a behavioural model at each falling edge, which is after the model has taken the same edge. Directed register reads are taken in the low phase, after the known number of edges has passed. For example, a counter loaded with L and then started is read after exactly L ticks to see its expiry, and after one more tick to see the reload.

// File: rtl/dual_systimer_pkg.sv
package dual_systimer_pkg;

    localparam int N_TMR  = 2;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LOAD0 = 3'd0,
        SEL_CNT0  = 3'd1,
        SEL_CTRL0 = 3'd2,
        SEL_LOAD1 = 3'd3,
        SEL_CNT1  = 3'd4,
        SEL_CTRL1 = 3'd5,
        SEL_STAT  = 3'd6,
        SEL_MODE  = 3'd7
    } reg_sel_e;

    // bit 0 run, bit 1 one-shot, bit 2 irq enable
    typedef struct packed {
        logic irq_en;
        logic one_shot;
        logic run;
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);

    // per-slice action for one clock edge
    typedef struct packed {
        logic dec;
        logic reload;
        logic expire;
        logic stop;
    } tmr_step_t;

    // decoded view of a slice, fed back to the sequencer
    typedef struct packed {
        logic zero;
        logic one;
        logic load_zero;
    } tmr_view_t;

    function automatic reg_sel_e load_sel(input int idx);
        return (idx == 0) ? SEL_LOAD0 : SEL_LOAD1;
    endfunction

    function automatic reg_sel_e cnt_sel(input int idx);
        return (idx == 0) ? SEL_CNT0 : SEL_CNT1;
    endfunction

    function automatic reg_sel_e ctrl_sel(input int idx);
        return (idx == 0) ? SEL_CTRL0 : SEL_CTRL1;
    endfunction

endpackage

// File: rtl/dual_systimer_slice.sv
module dual_systimer_slice
    import dual_systimer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_step_t        step_i,
    input  logic             set_i,
    input  logic [CNT_W-1:0] set_val_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output tmr_view_t        view_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (set_i) begin
            cnt_q <= set_val_i;
        end else if (step_i.reload) begin
            cnt_q <= load_val_i;
        end else if (step_i.dec) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign cnt_o            = cnt_q;
    assign view_o.zero      = (cnt_q == '0);
    assign view_o.one       = (cnt_q == CNT_W'(1));
    assign view_o.load_zero = (load_val_i == '0);

    // R2: one step down per enabled tick
    a_r2_dec_one: assert property (@(posedge clk) disable iff (rst)
        step_i.dec && !step_i.reload && !set_i |=> cnt_q == $past(cnt_q) - CNT_W'(1));

    // R4: reload takes the load value
    a_r4_reload_value: assert property (@(posedge clk) disable iff (rst)
        step_i.reload && !set_i |=> cnt_q == $past(load_val_i));

    // R2: no action means no change
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !step_i.dec && !step_i.reload && !set_i |=> $stable(cnt_q));

endmodule

// File: rtl/dual_systimer_step.sv
module dual_systimer_step
    import dual_systimer_pkg::*;
(
    input  logic                  tick_i,
    input  logic                  chain_i,
    input  logic [N_TMR-1:0]      run_i,
    input  logic [N_TMR-1:0]      one_shot_i,
    input  tmr_view_t [N_TMR-1:0] view_i,
    output tmr_step_t [N_TMR-1:0] step_o
);

    logic [N_TMR-1:0] act;
    logic             join_zero;
    logic             join_one;
    logic             join_load_zero;

    assign act            = {N_TMR{tick_i}} & run_i;
    assign join_zero      = view_i[0].zero & view_i[1].zero;
    assign join_one       = view_i[0].one & view_i[1].zero;
    assign join_load_zero = view_i[0].load_zero & view_i[1].load_zero;

    always_comb begin
        step_o = '0;
        if (!chain_i) begin
            for (int i = 0; i < N_TMR; i++) begin
                if (view_i[i].zero) begin
                    step_o[i].reload = act[i] & ~one_shot_i[i];
                    step_o[i].expire = act[i] & ~one_shot_i[i] & view_i[i].load_zero;
                    step_o[i].stop   = act[i] & one_shot_i[i];
                end else begin
                    step_o[i].dec    = act[i];
                    step_o[i].expire = act[i] & view_i[i].one;
                    step_o[i].stop   = act[i] & view_i[i].one & one_shot_i[i];
                end
            end
        end else begin
            if (join_zero) begin
                step_o[0].reload = act[0] & ~one_shot_i[0];
                step_o[1].reload = act[0] & ~one_shot_i[0];
                step_o[0].expire = act[0] & ~one_shot_i[0] & join_load_zero;
                step_o[0].stop   = act[0] & one_shot_i[0];
            end else begin
                step_o[0].dec    = act[0];
                step_o[1].dec    = act[0] & view_i[0].zero;
                step_o[0].expire = act[0] & join_one;
                step_o[0].stop   = act[0] & join_one & one_shot_i[0];
            end
        end
    end

endmodule

// File: rtl/dual_systimer_regs.sv
module dual_systimer_regs
    import dual_systimer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [CNT_W-1:0]             wdata_i,
    input  logic [N_TMR-1:0]             hw_set_i,
    input  logic [N_TMR-1:0]             hw_stop_i,
    output logic [N_TMR-1:0][CNT_W-1:0]  load_o,
    output tmr_ctrl_t [N_TMR-1:0]        ctrl_o,
    output logic [N_TMR-1:0]             flag_o,
    output logic                         chain_o
);

    reg_sel_e         sel;
    logic [N_TMR-1:0] clr_req;

    assign sel     = reg_sel_e'(addr_i);
    assign clr_req = (wr_en_i && sel == SEL_STAT) ? wdata_i[N_TMR-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_o  <= '0;
            ctrl_o  <= '0;
            flag_o  <= '0;
            chain_o <= 1'b0;
        end else begin
            for (int i = 0; i < N_TMR; i++) begin
                if (wr_en_i && sel == load_sel(i)) begin
                    load_o[i] <= wdata_i;
                end
                if (wr_en_i && sel == ctrl_sel(i)) begin
                    ctrl_o[i] <= tmr_ctrl_t'(wdata_i[CTRL_W-1:0]);
                end else if (hw_stop_i[i]) begin
                    ctrl_o[i].run <= 1'b0;
                end
            end
            flag_o <= (flag_o & ~clr_req) | hw_set_i;
            if (wr_en_i && sel == SEL_MODE) begin
                chain_o <= wdata_i[0];
            end
        end
    end

    for (genvar g = 0; g < N_TMR; g++) begin : g_flag_chk
        // R3: an expiry always lands in the status flag
        a_r3_flag_set: assert property (@(posedge clk) disable iff (rst)
            hw_set_i[g] |=> flag_o[g]);
        // R7: write-one clears when hardware is not setting
        a_r7_w1c_clear: assert property (@(posedge clk) disable iff (rst)
            clr_req[g] && !hw_set_i[g] |=> !flag_o[g]);
    end

endmodule

// File: rtl/dual_systimer.sv
module dual_systimer
    import dual_systimer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic [N_TMR-1:0]  irq_o
);

    reg_sel_e                    sel;
    logic [N_TMR-1:0][CNT_W-1:0] load_val;
    logic [N_TMR-1:0][CNT_W-1:0] cnt_val;
    tmr_ctrl_t [N_TMR-1:0]       ctrl;
    logic [N_TMR-1:0]            flag;
    logic                        chain;
    tmr_view_t [N_TMR-1:0]       view;
    tmr_step_t [N_TMR-1:0]       step;
    logic [N_TMR-1:0]            hw_set;
    logic [N_TMR-1:0]            hw_stop;
    logic [N_TMR-1:0]            run_vec;
    logic [N_TMR-1:0]            os_vec;
    logic [N_TMR-1:0]            gate_run;
    logic [N_TMR-1:0]            cnt_wr;

    assign sel = reg_sel_e'(addr_i);

    dual_systimer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .hw_set_i  (hw_set),
        .hw_stop_i (hw_stop),
        .load_o    (load_val),
        .ctrl_o    (ctrl),
        .flag_o    (flag),
        .chain_o   (chain)
    );

    dual_systimer_step u_step (
        .tick_i     (tick_i),
        .chain_i    (chain),
        .run_i      (run_vec),
        .one_shot_i (os_vec),
        .view_i     (view),
        .step_o     (step)
    );

    for (genvar g = 0; g < N_TMR; g++) begin : g_slice
        assign run_vec[g] = ctrl[g].run;
        assign os_vec[g]  = ctrl[g].one_shot;
        assign hw_set[g]  = step[g].expire;
        assign hw_stop[g] = step[g].stop;
        // in chained mode counter 0 decides whether both words are idle
        assign gate_run[g] = (chain && g != 0) ? ctrl[0].run : ctrl[g].run;
        assign cnt_wr[g]   = wr_en_i && (sel == load_sel(g)) && !gate_run[g];

        dual_systimer_slice #(.CNT_W(CNT_W)) u_slice (
            .clk        (clk),
            .rst        (rst),
            .step_i     (step[g]),
            .set_i      (cnt_wr[g]),
            .set_val_i  (wdata_i),
            .load_val_i (load_val[g]),
            .cnt_o      (cnt_val[g]),
            .view_o     (view[g])
        );
    end

    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_LOAD0: rdata_o = load_val[0];
            SEL_CNT0:  rdata_o = cnt_val[0];
            SEL_CTRL0: rdata_o = CNT_W'(ctrl[0]);
            SEL_LOAD1: rdata_o = load_val[1];
            SEL_CNT1:  rdata_o = cnt_val[1];
            SEL_CTRL1: rdata_o = CNT_W'(ctrl[1]);
            SEL_STAT:  rdata_o = CNT_W'(flag);
            SEL_MODE:  rdata_o = CNT_W'(chain);
            default:   rdata_o = '0;
        endcase
    end

    assign irq_o[0] = flag[0] & ctrl[0].irq_en;
    assign irq_o[1] = flag[1] & ctrl[1].irq_en & ~chain;

    // R5: a one-shot counter stops on its expiring tick
    a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
        !chain && tick_i && ctrl[0].run && ctrl[0].one_shot && cnt_val[0] == CNT_W'(1)
        && !(wr_en_i && sel == SEL_CTRL0) |=> !ctrl[0].run);

    // R9: low-word wrap borrows from the high word
    a_r9_carry: assert property (@(posedge clk) disable iff (rst)
        chain && tick_i && ctrl[0].run && cnt_val[0] == '0 && cnt_val[1] != '0
        |=> cnt_val[1] == $past(cnt_val[1]) - CNT_W'(1) && cnt_val[0] == '1);

    // R10: chained mode never raises the high-word flag
    a_r10_no_high_flag: assert property (@(posedge clk) disable iff (rst)
        chain && !flag[1] && !(wr_en_i && sel == SEL_MODE) |=> !flag[1]);

endmodule

// File: tb/dual_systimer_test.sv
module dual_systimer_test;

    localparam int CLK_PERIOD = 20;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    addr = 3'd0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata;
    logic [1:0]    irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    dual_systimer #(.CNT_W(W)) uut (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    logic [W-1:0] m_ld [2];
    logic [W-1:0] m_cn [2];
    logic [W-1:0] nc   [2];
    logic         m_run[2], m_os[2], m_ie[2], m_fl[2];
    logic         m_ch;
    logic [1:0]   setv, stopv, clrv;
    logic         g0, g1;
    logic [63:0]  big;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2; i++) begin
                m_ld[i] = '0; m_cn[i] = '0; m_run[i] = 0; m_os[i] = 0; m_ie[i] = 0; m_fl[i] = 0;
            end
            m_ch = 0;
        end else begin
            setv = '0; stopv = '0;
            nc[0] = m_cn[0]; nc[1] = m_cn[1];
            g0 = !m_run[0];
            g1 = m_ch ? !m_run[0] : !m_run[1];
            if (tick) begin
                if (!m_ch) begin
                    for (int i = 0; i < 2; i++) begin
                        if (m_run[i]) begin
                            if (m_cn[i] == 0) begin
                                if (m_os[i]) stopv[i] = 1;
                                else begin
                                    nc[i] = m_ld[i];
                                    if (m_ld[i] == 0) setv[i] = 1;
                                end
                            end else begin
                                nc[i] = m_cn[i] - 1;
                                if (m_cn[i] == 1) begin
                                    setv[i] = 1;
                                    if (m_os[i]) stopv[i] = 1;
                                end
                            end
                        end
                    end
                end else if (m_run[0]) begin
                    big = {m_cn[1], m_cn[0]};
                    if (big == 0) begin
                        if (m_os[0]) stopv[0] = 1;
                        else begin
                            big = {m_ld[1], m_ld[0]};
                            if (big == 0) setv[0] = 1;
                        end
                    end else begin
                        big = big - 1;
                        if (big == 0) begin
                            setv[0] = 1;
                            if (m_os[0]) stopv[0] = 1;
                        end
                    end
                    nc[0] = big[31:0];
                    nc[1] = big[63:32];
                end
            end
            clrv = '0;
            for (int i = 0; i < 2; i++)
                if (stopv[i] && !(wr_en && addr == 3'(2 + 3 * i))) m_run[i] = 0;
            if (wr_en) begin
                case (addr)
                    3'd0: begin m_ld[0] = wdata; if (g0) nc[0] = wdata; end
                    3'd3: begin m_ld[1] = wdata; if (g1) nc[1] = wdata; end
                    3'd2: begin m_run[0] = wdata[0]; m_os[0] = wdata[1]; m_ie[0] = wdata[2]; end
                    3'd5: begin m_run[1] = wdata[0]; m_os[1] = wdata[1]; m_ie[1] = wdata[2]; end
                    3'd6: clrv = wdata[1:0];
                    3'd7: m_ch = wdata[0];
                    default: ;
                endcase
            end
            for (int i = 0; i < 2; i++) begin
                m_fl[i] = (m_fl[i] & ~clrv[i]) | setv[i];
                m_cn[i] = nc[i];
            end
        end
    end

    function automatic logic [W-1:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_ld[0];
            3'd1: return m_cn[0];
            3'd2: return W'({m_ie[0], m_os[0], m_run[0]});
            3'd3: return m_ld[1];
            3'd4: return m_cn[1];
            3'd5: return W'({m_ie[1], m_os[1], m_run[1]});
            3'd6: return W'({m_fl[1], m_fl[0]});
            default: return W'(m_ch);
        endcase
    endfunction

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison with the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(W'(irq), W'({m_fl[1] & m_ie[1] & ~m_ch, m_fl[0] & m_ie[0]}), "R3 irq vs model");
            check(rdata, model_read(addr), "R12 rdata vs model");
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) begin
            @(negedge clk);
            #2;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [W-1:0] exp, input string tag);
        addr = a;
        #1;
        check(rdata, exp, tag);
    endtask

    task automatic chk_irq(input logic [1:0] exp, input string tag);
        #1;
        check(W'(irq), W'(exp), tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        rd(3'd0, 0, "R1 load0"); rd(3'd1, 0, "R1 cnt0"); rd(3'd2, 0, "R1 ctrl0"); chk_irq(2'b00, "R1 irq");
        cyc(1);
        rd(3'd3, 0, "R1 load1"); rd(3'd4, 0, "R1 cnt1"); rd(3'd5, 0, "R1 ctrl1");
        cyc(1);
        rd(3'd6, 0, "R1 stat"); rd(3'd7, 0, "R1 mode");
        cyc(1);

        // R6 load while stopped, R12 control readback
        wr(3'd0, 5);
        rd(3'd1, 5, "R6 idle load copies count");
        wr(3'd2, 5);
        rd(3'd2, 5, "R12 ctrl0 readback");
        cyc(3);
        rd(3'd1, 5, "R2 no tick no change");
        tick = 1'b1;
        cyc(2);
        rd(3'd1, 3, "R2 decrement per tick");
        cyc(3);
        rd(3'd1, 0, "R3 count at expiry"); rd(3'd6, 1, "R3 flag set"); chk_irq(2'b01, "R3 irq0 raised");
        cyc(1);
        rd(3'd1, 5, "R4 periodic reload");
        wr(3'd6, 0);
        rd(3'd6, 1, "R7 write zero keeps flag");
        wr(3'd6, 1);
        rd(3'd6, 0, "R7 write one clears"); chk_irq(2'b00, "R7 irq cleared");
        wr(3'd0, 9);
        rd(3'd1, 2, "R6 running load leaves count"); rd(3'd0, 9, "R6 load updated");
        cyc(2);
        rd(3'd1, 0, "R4 second expiry");
        cyc(1);
        rd(3'd1, 9, "R6 new load at reload");

        // R5 one-shot
        tick = 1'b0;
        wr(3'd2, 7);
        wr(3'd6, 1);
        tick = 1'b1;
        cyc(9);
        rd(3'd1, 0, "R5 one-shot reaches zero"); rd(3'd2, 6, "R5 run bit cleared"); rd(3'd6, 1, "R5 flag");
        cyc(3);
        rd(3'd1, 0, "R5 holds zero"); rd(3'd2, 6, "R5 stays stopped");
        rd(3'd4, 0, "R11 counter1 untouched");

        // R11 counter 1 alone
        tick = 1'b0;
        wr(3'd3, 3);
        wr(3'd5, 5);
        wr(3'd6, 3);
        tick = 1'b1;
        cyc(3);
        rd(3'd4, 0, "R11 counter1 expiry"); rd(3'd6, 2, "R11 only flag1"); chk_irq(2'b10, "R11 only irq1");
        rd(3'd1, 0, "R11 counter0 unchanged");

        // R8 zero load periodic
        tick = 1'b0;
        wr(3'd5, 0);
        wr(3'd3, 0);
        wr(3'd6, 3);
        wr(3'd5, 5);
        tick = 1'b1;
        cyc(1);
        rd(3'd6, 2, "R8 flag on first tick"); rd(3'd4, 0, "R8 count stays zero");
        wr(3'd6, 2);
        rd(3'd6, 2, "R7 set beats clear");
        wr(3'd6, 2);
        rd(3'd6, 2, "R8 flag every tick");

        // R9 chained borrow
        tick = 1'b0;
        wr(3'd5, 0);
        wr(3'd2, 0);
        wr(3'd6, 3);
        wr(3'd7, 1);
        wr(3'd0, 2);
        wr(3'd3, 1);
        rd(3'd4, 1, "R9 high load copied with counter0 stopped");
        wr(3'd2, 5);
        tick = 1'b1;
        cyc(2);
        rd(3'd1, 0, "R9 low word"); rd(3'd4, 1, "R9 high holds until wrap");
        cyc(1);
        rd(3'd1, 32'hFFFF_FFFF, "R9 low wraps"); rd(3'd4, 0, "R9 high borrows"); rd(3'd6, 0, "R9 no early flag");

        // R10 chained expiry
        tick = 1'b0;
        wr(3'd2, 0);
        wr(3'd0, 1);
        wr(3'd3, 0);
        wr(3'd5, 5);
        wr(3'd6, 3);
        wr(3'd2, 5);
        tick = 1'b1;
        cyc(1);
        rd(3'd1, 0, "R10 joined zero"); rd(3'd6, 1, "R10 flag0 only"); chk_irq(2'b01, "R10 irq1 low");
        cyc(1);
        rd(3'd1, 1, "R10 joined reload"); rd(3'd6, 1, "R10 flag1 stays clear"); chk_irq(2'b01, "R10 irq1 still low");

        // R1 reset mid-run
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        rd(3'd1, 0, "R1 cnt0 after reset"); rd(3'd7, 0, "R1 mode after reset"); chk_irq(2'b00, "R1 irq after reset");
        cyc(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule